// File: doc/BRIEF.md
# Gated UART Transmitter with Half-Duplex Receiver Lockout

This block is an 8N1 serial core. A byte pushed into a small queue waits there until the transmit path is free, then goes out on the serial output. A received frame shows up as a byte with a one-cycle valid strobe. An external enable sets the bit timing: one bit lasts 16 pulses of that enable. Two control bits, set through a plain write port, shape how the core behaves.

The transmit gate stands between the queue and the shift register. While the gate is closed, no byte leaves the queue. Closing the gate during a character lets that character finish. Opening the gate again resumes the queue in order.

The half-duplex bit puts transmitter and receiver on one shared wire. While the transmitter owns the line, the receiver is locked and ignores start bits. A character the receiver was already taking in is finished first. The lock is released one bit time after the transmitter's last stop bit, provided nothing else is waiting to go out. With the bit clear, transmitter and receiver work independently.

Top module: `uart_hd_core`

## Requirements
- R1: After reset the serial output is high, the queue is empty and not full, no receive strobe is raised, the transmit gate is open (1) and half-duplex is off (0).
- R2: Each transmitted frame is one low start bit, 8 data bits LSB first, then one high stop bit. Each bit lasts 16 baud-enable pulses.
- R3: While the transmit gate is 0, no queued byte enters the shift register and the output stays high.
- R4: Closing the gate during a character lets that character finish unchanged. The remaining bytes wait until the gate is set to 1 again.
- R5: A write with select 0 takes the gate from data bit 7. A write with select 1 takes half-duplex from data bit 0. All other data bits are ignored.
- R6: The queue holds 4 bytes and raises a full flag when it holds 4. A push while full is dropped. Bytes leave in push order.
- R7: The receiver confirms the start bit at mid-bit and samples each data bit at its middle. A good frame gives a one-cycle valid strobe with the byte.
- R8: A frame whose stop bit reads low gives a one-cycle framing-error pulse and no valid strobe.
- R9: With half-duplex off, a frame arriving while a transmission runs is received correctly.
- R10: With half-duplex on, an idle receiver is locked at once while the transmit path is busy. Start bits are then ignored and no strobe is produced.
- R11: With half-duplex on, a character already being received when transmission begins is completed and delivered.
- R12: The lock stays in force until one full bit time after the last stop bit ends with the transmit path empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| baud_tick | input | 1 | Oversampling enable, 16 pulses per bit |
| cfg_we | input | 1 | Control write strobe |
| cfg_sel | input | 1 | 0 selects the transmit gate word, 1 selects the duplex word |
| cfg_wdata | input | 8 | Control write data |
| push_valid | input | 1 | Push a byte into the transmit queue |
| push_data | input | 8 | Byte to push |
| fifo_full | output | 1 | Queue holds 4 bytes |
| txd | output | 1 | Serial transmit line, idles high |
| rxd | input | 1 | Serial receive line, idles high |
| rx_valid | output | 1 | One-cycle strobe: received byte valid |
| rx_data | output | 8 | Last received byte |
| rx_frame_err | output | 1 | One-cycle strobe: stop bit read low |

## Verification
The interesting overlap is a receive frame and a transmit frame on the same cycles. This happens with half-duplex off, where both must complete, and with it on, where the outcome depends on which side started first. The bench starts an incoming frame a few bit times into an outgoing one, and the other way round. It then compares the decoded output frames and the delivered bytes against queues of expected bytes. A further case starts an incoming frame just after the outgoing stop bit, inside the guard bit time. That frame must be ignored, while a frame sent after the guard is received.

// File: rtl/uart_hd_pkg.sv
package uart_hd_pkg;
  typedef enum logic {
    TXS_IDLE = 1'b0,
    TXS_SEND = 1'b1
  } tx_state_e;

  typedef enum logic [1:0] {
    RXS_IDLE  = 2'd0,
    RXS_START = 2'd1,
    RXS_DATA  = 2'd2,
    RXS_STOP  = 2'd3
  } rx_state_e;

  localparam logic CFG_SEL_GATE   = 1'b0;
  localparam logic CFG_SEL_DUPLEX = 1'b1;
endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               push_data,
  input  logic                       pop,
  output logic [W-1:0]               pop_data,
  output logic                       empty,
  output logic                       full,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push_ok, pop_ok;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign count   = cnt_q;
  assign pop_data = mem[rd_q];

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push_ok) wr_d = wrap_inc(wr_q);
    if (pop_ok)  rd_d = wrap_inc(rd_q);
    if (push_ok && !pop_ok)      cnt_d = cnt_q + 1'b1;
    else if (!push_ok && pop_ok) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= push_data;
  end
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_hd_pkg::*;
#(
  parameter int W   = 8,
  parameter int OVS = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_data,
  output logic         txd,
  output logic         busy,
  output logic         done
);
  localparam int FW = W + 2;
  localparam int BW = $clog2(FW);
  localparam int TW = $clog2(OVS);

  tx_state_e     st_q, st_d;
  logic [FW-1:0] frm_q, frm_d;
  logic [BW-1:0] bit_q, bit_d;
  logic [TW-1:0] tck_q, tck_d;
  logic          bit_end;

  assign busy    = (st_q == TXS_SEND);
  assign bit_end = busy && tick && (tck_q == TW'(OVS - 1));
  assign done    = bit_end && (bit_q == BW'(FW - 1));
  assign txd     = busy ? frm_q[0] : 1'b1;

  always_comb begin
    st_d  = st_q;
    frm_d = frm_q;
    bit_d = bit_q;
    tck_d = tck_q;
    case (st_q)
      TXS_IDLE: begin
        if (load) begin
          st_d  = TXS_SEND;
          frm_d = {1'b1, load_data, 1'b0};
          bit_d = '0;
          tck_d = '0;
        end
      end
      default: begin
        if (tick) begin
          if (bit_end) begin
            tck_d = '0;
            if (bit_q == BW'(FW - 1)) begin
              st_d = TXS_IDLE;
            end else begin
              bit_d = bit_q + 1'b1;
              frm_d = {1'b1, frm_q[FW-1:1]};
            end
          end else begin
            tck_d = tck_q + 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= TXS_IDLE;
      frm_q <= '1;
      bit_q <= '0;
      tck_q <= '0;
    end else begin
      st_q  <= st_d;
      frm_q <= frm_d;
      bit_q <= bit_d;
      tck_q <= tck_d;
    end
  end
endmodule

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
  import uart_hd_pkg::*;
#(
  parameter int W   = 8,
  parameter int OVS = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         rxd,
  input  logic         lock,
  output logic         busy,
  output logic         valid,
  output logic         ferr,
  output logic [W-1:0] data
);
  localparam int TW   = $clog2(OVS);
  localparam int BW   = (W > 1) ? $clog2(W) : 1;
  localparam int HALF = OVS / 2;

  rx_state_e     st_q, st_d;
  logic [TW-1:0] tck_q, tck_d;
  logic [BW-1:0] bit_q, bit_d;
  logic [W-1:0]  sh_q, sh_d, dat_q, dat_d;
  logic          val_q, val_d, fe_q, fe_d;
  logic          full_bit;

  assign busy     = (st_q != RXS_IDLE);
  assign valid    = val_q;
  assign ferr     = fe_q;
  assign data     = dat_q;
  assign full_bit = tick && (tck_q == TW'(OVS - 1));

  always_comb begin
    st_d  = st_q;
    tck_d = tck_q;
    bit_d = bit_q;
    sh_d  = sh_q;
    dat_d = dat_q;
    val_d = 1'b0;
    fe_d  = 1'b0;
    case (st_q)
      RXS_IDLE: begin
        tck_d = '0;
        if (!lock && !rxd) st_d = RXS_START;
      end
      RXS_START: begin
        if (tick) begin
          if (tck_q == TW'(HALF - 1)) begin
            tck_d = '0;
            bit_d = '0;
            st_d  = rxd ? RXS_IDLE : RXS_DATA;
          end else begin
            tck_d = tck_q + 1'b1;
          end
        end
      end
      RXS_DATA: begin
        if (full_bit) begin
          tck_d = '0;
          sh_d  = {rxd, sh_q[W-1:1]};
          if (bit_q == BW'(W - 1)) st_d = RXS_STOP;
          else                     bit_d = bit_q + 1'b1;
        end else if (tick) begin
          tck_d = tck_q + 1'b1;
        end
      end
      default: begin
        if (full_bit) begin
          tck_d = '0;
          st_d  = RXS_IDLE;
          if (rxd) begin
            val_d = 1'b1;
            dat_d = sh_q;
          end else begin
            fe_d = 1'b1;
          end
        end else if (tick) begin
          tck_d = tck_q + 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RXS_IDLE;
      tck_q <= '0;
      bit_q <= '0;
      sh_q  <= '0;
      dat_q <= '0;
      val_q <= 1'b0;
      fe_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      tck_q <= tck_d;
      bit_q <= bit_d;
      sh_q  <= sh_d;
      dat_q <= dat_d;
      val_q <= val_d;
      fe_q  <= fe_d;
    end
  end
endmodule

// File: rtl/uart_hd_core.sv
module uart_hd_core
  import uart_hd_pkg::*;
#(
  parameter int W          = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int OVS        = 16,
  parameter int CFG_W      = 8,
  parameter int GATE_BIT   = 7,
  parameter int DUPLEX_BIT = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             baud_tick,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             push_valid,
  input  logic [W-1:0]     push_data,
  output logic             fifo_full,
  output logic             txd,
  input  logic             rxd,
  output logic             rx_valid,
  output logic [W-1:0]     rx_data,
  output logic             rx_frame_err
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam int GW    = $clog2(OVS);

  logic [1:0]       rst_sync_q;
  logic             rst_n_i;
  logic             tx_en_q, tx_en_d, hd_en_q, hd_en_d;
  logic [1:0]       rxd_sync_q;
  logic             rxd_s;
  logic [W-1:0]     fifo_head;
  logic             fifo_empty;
  logic [CNT_W-1:0] fifo_count;
  logic             tx_load, tx_busy, tx_done;
  logic             tx_owns;
  logic             lock_q, lock_d;
  logic [GW-1:0]    guard_q, guard_d;
  logic             rx_lock, rx_busy;

  // Reset: asserted asynchronously, released on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  // Control bits: gate opens at reset, duplex mode full at reset.
  always_comb begin
    tx_en_d = tx_en_q;
    hd_en_d = hd_en_q;
    if (cfg_we) begin
      if (cfg_sel == CFG_SEL_GATE) tx_en_d = cfg_wdata[GATE_BIT];
      else                         hd_en_d = cfg_wdata[DUPLEX_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      tx_en_q    <= 1'b1;
      hd_en_q    <= 1'b0;
      rxd_sync_q <= 2'b11;
    end else begin
      tx_en_q    <= tx_en_d;
      hd_en_q    <= hd_en_d;
      rxd_sync_q <= {rxd_sync_q[0], rxd};
    end
  end
  assign rxd_s = rxd_sync_q[1];

  uart_tx_fifo #(.W(W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .push      (push_valid),
    .push_data (push_data),
    .pop       (tx_load),
    .pop_data  (fifo_head),
    .empty     (fifo_empty),
    .full      (fifo_full),
    .count     (fifo_count)
  );

  assign tx_load = tx_en_q && !fifo_empty && !tx_busy;

  uart_tx_shift #(.W(W), .OVS(OVS)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .tick      (baud_tick),
    .load      (tx_load),
    .load_data (fifo_head),
    .txd       (txd),
    .busy      (tx_busy),
    .done      (tx_done)
  );

  // Line ownership and receiver lock with a one-bit guard after release.
  assign tx_owns = tx_busy || (tx_en_q && !fifo_empty);

  always_comb begin
    lock_d  = lock_q;
    guard_d = guard_q;
    if (!hd_en_q) begin
      lock_d  = 1'b0;
      guard_d = '0;
    end else if (tx_owns) begin
      lock_d  = 1'b1;
      guard_d = '0;
    end else if (lock_q && baud_tick) begin
      if (guard_q == GW'(OVS - 1)) begin
        lock_d  = 1'b0;
        guard_d = '0;
      end else begin
        guard_d = guard_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      lock_q  <= 1'b0;
      guard_q <= '0;
    end else begin
      lock_q  <= lock_d;
      guard_q <= guard_d;
    end
  end

  assign rx_lock = lock_q || (hd_en_q && tx_owns);

  uart_rx_deser #(.W(W), .OVS(OVS)) u_rx (
    .clk   (clk),
    .rst_n (rst_n_i),
    .tick  (baud_tick),
    .rxd   (rxd_s),
    .lock  (rx_lock),
    .busy  (rx_busy),
    .valid (rx_valid),
    .ferr  (rx_frame_err),
    .data  (rx_data)
  );
endmodule

// File: rtl/uart_hd_checker.sv
module uart_hd_checker #(
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rst_n_i,
  input logic          tx_en_q,
  input logic          hd_en_q,
  input logic          tx_busy,
  input logic          tx_done,
  input logic          tx_load,
  input logic          txd,
  input logic          rx_lock,
  input logic          rx_busy,
  input logic          rx_valid,
  input logic          rx_frame_err,
  input logic          push_valid,
  input logic [CW-1:0] fifo_count
);
  assert_start_bit_low_R2: assert property (@(posedge clk) disable iff (!rst_n_i)
    $rose(tx_busy) |-> !txd);

  assert_gate_blocks_load_R3: assert property (@(posedge clk) disable iff (!rst_n_i)
    (!tx_en_q && !tx_busy) |=> !tx_busy);

  assert_char_completes_R4: assert property (@(posedge clk) disable iff (!rst_n_i)
    (tx_busy && !tx_done) |=> tx_busy);

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n_i)
    (fifo_count == CW'(DEPTH) && push_valid && !tx_load) |=> (fifo_count == CW'(DEPTH)));

  assert_strobes_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n_i)
    !(rx_valid && rx_frame_err));

  assert_full_duplex_free_R9: assert property (@(posedge clk) disable iff (!rst_n_i)
    !hd_en_q |-> !rx_lock);

  assert_lock_during_tx_R10: assert property (@(posedge clk) disable iff (!rst_n_i)
    (hd_en_q && tx_busy) |-> rx_lock);

  assert_locked_stays_idle_R10: assert property (@(posedge clk) disable iff (!rst_n_i)
    (rx_lock && !rx_busy) |=> !rx_busy);
endmodule

bind uart_hd_core uart_hd_checker #(.DEPTH(FIFO_DEPTH), .CW(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n_i      (rst_n_i),
  .tx_en_q      (tx_en_q),
  .hd_en_q      (hd_en_q),
  .tx_busy      (tx_busy),
  .tx_done      (tx_done),
  .tx_load      (tx_load),
  .txd          (txd),
  .rx_lock      (rx_lock),
  .rx_busy      (rx_busy),
  .rx_valid     (rx_valid),
  .rx_frame_err (rx_frame_err),
  .push_valid   (push_valid),
  .fifo_count   (fifo_count)
);

// File: tb/tb_uart_hd_core.sv
module tb_uart_hd_core;
  localparam int BITC = 32; // 16 ticks, one tick every 2 clocks

  logic       clk;
  logic       rst_n;
  logic       baud_tick;
  logic       cfg_we;
  logic       cfg_sel;
  logic [7:0] cfg_wdata;
  logic       push_valid;
  logic [7:0] push_data;
  logic       fifo_full;
  logic       txd;
  logic       rxd;
  logic       rx_valid;
  logic [7:0] rx_data;
  logic       rx_frame_err;

  int n_checks = 0;
  int n_fail   = 0;
  int tx_frames = 0;
  int ferr_cnt  = 0;
  bit finished  = 0;
  byte unsigned tx_exp[$], tx_got[$], rx_exp[$], rx_got[$];

  uart_hd_core dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .push_valid(push_valid), .push_data(push_data), .fifo_full(fifo_full),
    .txd(txd), .rxd(rxd), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_frame_err(rx_frame_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  initial begin
    baud_tick = 1'b0;
    forever @(negedge clk) baud_tick = ~baud_tick;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit frame_bit(input byte unsigned b, input int idx);
    if (idx == 0) return 1'b0;
    if (idx <= 8) return b[idx-1];
    return 1'b1;
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    finish_run();
  end

  // Output frame decoder
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && txd == 1'b0) begin
        byte unsigned b;
        repeat (BITC/2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
          repeat (BITC) @(negedge clk);
          b[i] = txd;
        end
        repeat (BITC) @(negedge clk);
        check(txd == 1'b1, "R2 stop bit", txd, 1);
        tx_got.push_back(b);
        tx_frames++;
      end
    end
  end

  // Receive strobe collector
  initial begin
    forever begin
      @(negedge clk);
      if (rx_valid) rx_got.push_back(rx_data);
      if (rx_frame_err) ferr_cnt++;
    end
  end

  task automatic cfg_write(input bit sel, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic push(input byte unsigned b);
    @(negedge clk);
    push_valid = 1'b1; push_data = b;
    if (!fifo_full) tx_exp.push_back(b);
    @(negedge clk);
    push_valid = 1'b0;
  endtask

  task automatic send_rx(input byte unsigned b, input bit good_stop);
    for (int i = 0; i < 9; i++) begin
      rxd = frame_bit(b, i);
      repeat (BITC) @(negedge clk);
    end
    if (good_stop) begin
      rxd = 1'b1;
      repeat (BITC) @(negedge clk);
    end else begin
      rxd = 1'b0;
      repeat (24) @(negedge clk);
      rxd = 1'b1;
    end
    repeat (BITC) @(negedge clk);
  endtask

  task automatic wait_tx(input int n);
    int t = 0;
    while (tx_frames < n && t < 4000) begin
      @(negedge clk);
      t++;
    end
  endtask

  task automatic compare_queues(input string req);
    check(tx_got.size() == tx_exp.size(), {req, " tx count"}, tx_got.size(), tx_exp.size());
    for (int i = 0; i < tx_exp.size() && i < tx_got.size(); i++)
      check(tx_got[i] == tx_exp[i], {req, " tx byte"}, tx_got[i], tx_exp[i]);
    check(rx_got.size() == rx_exp.size(), {req, " rx count"}, rx_got.size(), rx_exp.size());
    for (int i = 0; i < rx_exp.size() && i < rx_got.size(); i++)
      check(rx_got[i] == rx_exp[i], {req, " rx byte"}, rx_got[i], rx_exp[i]);
  endtask

  initial begin
    int n0;
    void'($urandom(32'd2024));
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
    push_valid = 1'b0; push_data = '0; rxd = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check(txd == 1'b1, "R1 txd idle", txd, 1);
    check(fifo_full == 1'b0, "R1 not full", fifo_full, 0);
    check(rx_valid == 1'b0 && rx_frame_err == 1'b0, "R1 no strobe", rx_valid, 0);

    // R1/R2: gate open by default, frame format
    push(8'hA5);
    wait_tx(1);
    compare_queues("R2");

    // R5/R3/R6: close gate through bit 7 only, fill queue past capacity
    cfg_write(1'b0, 8'h7F);
    for (int i = 0; i < 5; i++) push(byte'(8'h10 + i));
    check(fifo_full == 1'b1, "R6 full flag", fifo_full, 1);
    check(tx_exp.size() == 5, "R6 fifth push dropped", tx_exp.size(), 5);
    n0 = tx_frames;
    repeat (400) @(negedge clk);
    check(tx_frames == n0, "R3 no send while gated", tx_frames, n0);
    check(txd == 1'b1, "R3 line high while gated", txd, 1);
    cfg_write(1'b0, 8'h80);
    wait_tx(n0 + 4);
    compare_queues("R6");

    // R4: close gate mid-character
    n0 = tx_frames;
    push(8'h3E);
    push(8'hC1);
    while (txd == 1'b1) @(negedge clk);
    repeat (100) @(negedge clk);
    cfg_write(1'b0, 8'h00);
    wait_tx(n0 + 1);
    repeat (700) @(negedge clk);
    check(tx_frames == n0 + 1, "R4 only current char sent", tx_frames, n0 + 1);
    cfg_write(1'b0, 8'h80);
    wait_tx(n0 + 2);
    compare_queues("R4");

    // R5/R9: duplex word with bit 0 clear stays full duplex
    cfg_write(1'b1, 8'hFE);
    n0 = tx_frames;
    fork
      push(8'h6B);
      begin
        repeat (64) @(negedge clk);
        rx_exp.push_back(8'hD2);
        send_rx(8'hD2, 1'b1);
      end
    join
    wait_tx(n0 + 1);
    compare_queues("R9");

    // R7/R8: bad stop bit
    n0 = ferr_cnt;
    send_rx(8'h81, 1'b0);
    repeat (100) @(negedge clk);
    check(ferr_cnt == n0 + 1, "R8 framing pulse", ferr_cnt, n0 + 1);
    compare_queues("R8");
    rx_exp.push_back(8'h00);
    send_rx(8'h00, 1'b1);
    compare_queues("R7");

    // R10: half duplex, receive attempt while transmitting is ignored
    cfg_write(1'b1, 8'h01);
    n0 = tx_frames;
    push(8'h47);
    while (txd == 1'b1) @(negedge clk);
    repeat (64) @(negedge clk);
    send_rx(8'h3C, 1'b1);
    wait_tx(n0 + 1);
    repeat (200) @(negedge clk);
    compare_queues("R10");

    // R11: reception under way finishes when transmission starts
    n0 = tx_frames;
    rx_exp.push_back(8'h96);
    fork
      send_rx(8'h96, 1'b1);
      begin
        repeat (3 * BITC) @(negedge clk);
        push(8'h29);
      end
    join
    wait_tx(n0 + 1);
    repeat (200) @(negedge clk);
    compare_queues("R11");

    // R12: frame inside the guard bit is ignored, after the guard it is taken
    n0 = tx_frames;
    push(8'hE4);
    wait_tx(n0 + 1);
    repeat (8) @(negedge clk);
    send_rx(8'hFF, 1'b1);
    repeat (100) @(negedge clk);
    compare_queues("R12 guard");
    rx_exp.push_back(8'h5A);
    send_rx(8'h5A, 1'b1);
    compare_queues("R12 after guard");

    // R9/R6: random mixed traffic in full duplex
    cfg_write(1'b1, 8'h00);
    for (int r = 0; r < 3; r++) begin
      fork
        for (int i = 0; i < 6; i++) begin
          repeat ($urandom_range(0, 150)) @(negedge clk);
          push(byte'($urandom_range(0, 255)));
        end
        for (int i = 0; i < 4; i++) begin
          byte unsigned b;
          b = byte'($urandom_range(0, 255));
          rx_exp.push_back(b);
          send_rx(b, 1'b1);
        end
      join
      wait_tx(tx_exp.size());
      repeat (100) @(negedge clk);
      compare_queues("R9 random");
    end

    finish_run();
  end
endmodule